// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A character of up to nine bits is offered on a valid/ready input. When it is taken, the block sends a low start bit. The active data bits follow, least significant first. An optional parity bit comes next, and a single high stop bit ends the frame. The line rests high between frames.

Four run-time inputs set the frame shape. A 2-bit code chooses the word length. One input turns parity on or off, and another chooses odd or even parity. A 16-bit divisor sets the bit time: every bit on the line lasts exactly that many clock cycles. Divisors below 16 are raised to 16. All four settings are taken at the moment a character is accepted, so software may change them while a frame is still in flight.

The busy flag drops in the last cycle of the stop bit, and the ready output rises in that same cycle. A character offered then starts its start bit right after the stop bit. Frames can therefore follow one another with no extra high time on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a frame, the line is high, busy is low and ready is high. While not busy, the line stays high.
- R2: A character is accepted on a clock edge where valid and ready are both high. From the next cycle, busy is high and ready is low until the frame ends. Characters offered while busy are not taken.
- R3: A frame is a low start bit, then the data bits, then the parity bit when enabled, then one high stop bit.
- R4: Word-length code 2'b00 sends 7 data bits, 2'b01 sends 8 and 2'b10 sends 9. Code 2'b11 sends 8. Data bits go out bit 0 first, and data bits above the chosen length are not sent.
- R5: With parity enabled, one parity bit follows the last data bit. Parity sense 1 makes the count of ones over the data bits plus parity odd, and sense 0 makes it even. Parity is computed over the active data bits only.
- R6: Every bit of the frame, the stop bit included, holds the line for exactly D clock cycles, where D is the divisor captured with the character.
- R7: A divisor input below 16, including 0, is used as 16.
- R8: Word-length code, parity enable, parity sense, divisor and data are captured at acceptance. Changing them during the frame does not alter that frame.
- R9: Busy goes low and ready goes high in the last cycle of the stop bit. A character accepted at the end of that cycle puts its start bit on the line in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; bit timing counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The block can take a character this cycle |
| in_data | input | DATA_W (9) | Character; only the active low bits are sent |
| cfg_wlen | input | 2 | Word-length code (00: 7, 01: 8, 10: 9, 11: 8 bits) |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_div | input | DIV_W (16) | Clock cycles per bit; raised to 16 if smaller |
| tx_line | output | 1 | Serial output, high when idle |
| tx_busy | output | 1 | A frame is being sent |

## Verification
The hardest situation to reach is the handover between frames. The stop bit has to last a full D cycles while the next start bit follows at once. At the same moment, the configuration inputs are already carrying the settings for some later character. The stimulus reaches this by offering the next character in the very cycle ready rises. On many frames it also scrambles every configuration input and the data right after acceptance, and it keeps valid high through the frame. The line is compared with the expected frame on every cycle, so a stop bit that is too short or too long, a gap, or a frame built from the wrong settings all show up.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    WL_7   = 2'b00,
    WL_8   = 2'b01,
    WL_9   = 2'b10,
    WL_RSV = 2'b11
  } wlen_e;

  typedef struct packed {
    wlen_e wlen;
    logic  par_en;
    logic  par_odd;
  } fmt_t;

  function automatic int data_len(wlen_e w);
    case (w)
      WL_7:    return 7;
      WL_9:    return 9;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  fmt_t               fmt,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);

  int                ndata;
  logic [DATA_W-1:0] masked;
  logic              par_bit;

  assign ndata = data_len(fmt.wlen);

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign masked[g] = data[g] & (g < ndata);
  end

  assign par_bit = fmt.par_odd ? ~(^masked) : (^masked);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < ndata) frame[i+1] = data[i];
    end
    if (fmt.par_en) frame[ndata+1] = par_bit;
  end

  assign nbits = CNT_W'(ndata + 2 + int'(fmt.par_en));

  always_comb begin
    a_len_r4: assert (ndata >= 7 && ndata <= DATA_W);
  end

endmodule

// File: rtl/uart_tx_bittimer.sv
module uart_tx_bittimer #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  input  logic             reload,
  input  logic             reload_short,
  output logic             tick
);

  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] clamp;

  assign clamp = (div_in < FLOOR) ? FLOOR : div_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= FLOOR;
      cnt   <= '0;
    end else if (load) begin
      div_q <= clamp;
      cnt   <= clamp - 1'b1;
    end else if (reload) begin
      cnt <= reload_short ? (div_q - 2'd2) : (div_q - 1'b1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);

  p_div_floor_r7: assert property (@(posedge clk) disable iff (rst)
    run |-> div_q >= FLOOR);

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt < div_q);

  p_div_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(div_q));

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  input  logic               tick,
  output logic               busy,
  output logic               tx,
  output logic               reload,
  output logic               reload_short
);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tx   <= 1'b1;
      sh   <= '1;
      left <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      tx   <= frame[0];
      sh   <= {1'b1, frame[FRAME_W-1:1]};
      left <= nbits - 1'b1;
    end else if (tick) begin
      if (left == '0) begin
        busy <= 1'b0;
        tx   <= 1'b1;
      end else begin
        tx   <= sh[0];
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 1'b1;
      end
    end
  end

  assign reload       = tick && (left != '0);
  assign reload_short = (left == CNT_W'(1));

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);

  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    accept |-> !busy);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !tx);

  p_left_bound_r4: assert property (@(posedge clk) disable iff (rst)
    left < CNT_W'(FRAME_W));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              tx_line,
  output logic              tx_busy
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  fmt_t               fmt;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               accept;
  logic               busy;
  logic               tick;
  logic               reload;
  logic               reload_short;

  assign fmt    = '{wlen: wlen_e'(cfg_wlen), par_en: cfg_par_en, par_odd: cfg_par_odd};
  assign accept = in_valid && !busy;

  uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .data  (in_data),
    .fmt   (fmt),
    .frame (frame),
    .nbits (nbits)
  );

  uart_tx_bittimer #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .load         (accept),
    .div_in       (cfg_div),
    .run          (busy),
    .reload       (reload),
    .reload_short (reload_short),
    .tick         (tick)
  );

  uart_tx_serializer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_ser (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .frame        (frame),
    .nbits        (nbits),
    .tick         (tick),
    .busy         (busy),
    .tx           (tx_line),
    .reload       (reload),
    .reload_short (reload_short)
  );

  assign in_ready = !busy;
  assign tx_busy  = busy;

  p_end_ready_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> in_ready && tx_line);

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [8:0]  in_data = '0;
  logic [1:0]  cfg_wlen = '0;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic [15:0] cfg_div = 16'd16;
  logic        tx_line;
  logic        tx_busy;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_div(cfg_div),
    .tx_line(tx_line), .tx_busy(tx_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dlen(logic [1:0] w);
    return (w == 2'b00) ? 7 : (w == 2'b10) ? 9 : 8;
  endfunction

  function automatic logic [11:0] exp_frame(logic [8:0] d, logic [1:0] w, logic pe, logic po);
    int n = dlen(w);
    int ones = 0;
    logic [11:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (pe) f[n+1] = po ? (ones % 2 == 0) : (ones % 2 == 1);
    return f;
  endfunction

  // Called just after a negedge; returns at the negedge of the last stop-bit cycle.
  task automatic send(input logic [8:0] d, input logic [1:0] w, input logic pe,
                      input logic po, input logic [15:0] dv, input bit scramble);
    int dd = (dv < 16) ? 16 : int'(dv);
    int n = dlen(w);
    int tot = n + 2 + int'(pe);
    logic [11:0] fr = exp_frame(d, w, pe, po);
    int edge_bad = 0;
    int busy_bad = 0;
    string lbl;
    in_valid = 1'b1; in_data = d; cfg_wlen = w;
    cfg_par_en = pe; cfg_par_odd = po; cfg_div = dv;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    for (int c = 0; c < tot * dd; c++) begin
      int j = c / dd;
      @(negedge clk);
      if (c == 0) begin
        in_valid = scramble;  // R2: held valid while busy must be ignored
        if (scramble) begin   // R8: settings change mid-frame
          in_data = 9'($urandom); cfg_wlen = 2'($urandom);
          cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
          cfg_div = 16'($urandom % 8);
        end
      end
      if (c == tot * dd - 1) in_valid = 1'b0;
      if (tx_line !== fr[j]) edge_bad++;
      if (c < tot * dd - 1 && (tx_busy !== 1'b1 || in_ready !== 1'b0)) busy_bad++;
      if (c % dd == dd / 2) begin
        if (j == 0) lbl = "R3 start bit";
        else if (j <= n) lbl = "R4 data bit";
        else if (pe && j == n + 1) lbl = "R5 parity bit";
        else lbl = "R3 stop bit";
        chk(tx_line === fr[j], lbl, int'(tx_line), int'(fr[j]));
      end
    end
    chk(edge_bad == 0, (dv < 16) ? "R7 clamped bit time" : "R6 bit time / R8 captured", edge_bad, 0);
    chk(busy_bad == 0, "R2 busy and ready during frame", busy_bad, 0);
    chk(tx_busy === 1'b0 && in_ready === 1'b1 && tx_line === 1'b1, "R9 release in last stop cycle",
        int'({tx_busy, in_ready, tx_line}), 3'b011);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_line === 1'b1 && tx_busy === 1'b0 && in_ready === 1'b1, "R1 reset state",
        int'({tx_line, tx_busy, in_ready}), 3'b101);

    // Directed corner cases
    send(9'h1FF, 2'b00, 1'b0, 1'b0, 16'd16, 1'b0);  // R4 7 bits
    send(9'h0AA, 2'b01, 1'b1, 1'b0, 16'd16, 1'b0);  // R5 even
    send(9'h155, 2'b10, 1'b1, 1'b1, 16'd17, 1'b0);  // R5 odd, 9 bits
    send(9'h1C3, 2'b11, 1'b1, 1'b1, 16'd0,  1'b0);  // R4 code 11, R7 div 0
    send(9'h000, 2'b10, 1'b1, 1'b1, 16'd15, 1'b1);  // R7 div 15, R8
    send(9'h1FF, 2'b01, 1'b1, 1'b0, 16'd40, 1'b1);  // R6 longer bit

    // Random frames, often back to back (R9)
    for (int k = 0; k < 30; k++) begin
      send(9'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           16'(14 + $urandom % 10), 1'($urandom));
      if ($urandom % 4 == 0) repeat (1 + $urandom % 5) @(negedge clk);
    end

    // R1: reset in the middle of a frame
    in_valid = 1'b1; in_data = 9'h000; cfg_wlen = 2'b01; cfg_div = 16'd16;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(tx_line === 1'b1 && tx_busy === 1'b0 && in_ready === 1'b1, "R1 reset mid-frame",
        int'({tx_line, tx_busy, in_ready}), 3'b101);
    repeat (20) @(negedge clk);
    chk(tx_line === 1'b1, "R1 idle line stays high", int'(tx_line), 1);
    send(9'h05A, 2'b01, 1'b0, 1'b0, 16'd16, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule